// File: doc/BRIEF.md
# Multi-Line DMA Transmit Scheduler

This block feeds bytes from memory to up to sixteen serial transmit lines through a single shared memory read port. Software reaches every line through one small register window. A select field in the control word chooses the line whose address and count words are visible. Software loads a start address and the negated length for that line, then sets the line's bit in the active mask.

The scheduler visits active lines in rotating order. Only a line whose transmitter can take a byte is eligible. For each visit it makes one memory read and passes the returned byte to that line's transmitter. It then steps the line's address and count. When the count wraps to zero, the line's active bit drops and a completion flag is raised.

A memory error ends the line early. The error sets a separate flag and leaves the line's address and count at the failing position. Both flags feed a single interrupt output through a shared enable bit. Serialisation onto the wire belongs to the transmitters and is not part of this block.

Top module: `dma_tx_scheduler`

## Requirements
- R1: After reset, the control, active-mask, address and count words read zero, and `mem_req`, `tx_valid` and `irq` are low.
- R2: Register word 0 is control, 1 is address, 2 is count and 3 is the active mask, selected by `reg_idx`. Control bits [3:0] select the line whose address and count words are read and written. Control bit 13 is the interrupt enable.
- R3: The count is loaded as the two's-complement negative of the byte total. Each delivered byte adds one to both the line's address and its count. The line finishes when its count becomes zero, so a line loaded with -n delivers exactly n bytes read from consecutive addresses.
- R4: Active-mask bit i is set by software to start line i, and no line whose bit is clear is fetched. Hardware clears the bit when the line finishes or takes a memory error. A software write to the mask in the same cycle takes priority.
- R5: Eligible lines are served one byte per grant in round-robin order, starting after the last line served. After reset, line 0 is the first candidate.
- R6: A line is fetched only while its `tx_ready` is high. Each byte is delivered as a one-cycle pulse on that line's `tx_valid` bit (never more than one bit at a time), with the memory byte on `tx_data`.
- R7: `mem_req` stays high with `mem_addr` stable until `mem_gnt`. Data and error are taken in the grant cycle, and the byte appears on the transmitter outputs one cycle later.
- R8: Control bit 15 sets when any line finishes. Writing 0 to it clears it, and writing 1 leaves it unchanged. A completion in the same cycle wins.
- R9: A grant with `mem_err` high sets control bit 10 and clears the line's active bit. No byte is delivered, and the line's address and count stay at the failing values. Writing 1 to control bit 8 clears bit 10.
- R10: `irq` is high exactly when control bit 13 is set and bit 15 or bit 10 is set.
- R11: Clearing a line's active bit while it waits for its transmitter prevents any fetch for it. Its address is then left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register word select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory byte address |
| mem_gnt | input | 1 | Memory grant, data valid |
| mem_rdata | input | 8 | Memory read byte |
| mem_err | input | 1 | Non-existent memory response |
| tx_ready | input | 16 | Per-line transmitter can accept a byte |
| tx_valid | output | 16 | Per-line byte strobe |
| tx_data | output | 8 | Byte for the strobed line |
| irq | output | 1 | Transmit/error interrupt |

## Verification
The assertions rely on two properties of the inputs. Once a transmitter raises `tx_ready`, it keeps it high until it receives a byte. Software does not rewrite the address of a line while that line's request is outstanding. The stimulus keeps to both rules: it lowers a ready bit only before the line is activated, and it reprograms a line only after that line's active bit reads clear. The memory model withholds grants on some cycles, so that the request is held across waits. It signals errors only inside a fixed address window, which only the error sweep touches.

// File: rtl/dts_pkg.sv
// Shared definitions for the DMA transmit scheduler.
// Assumes the register data width is 16 and the line count is at most 16.
package dts_pkg;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_ADDR = 2'd1;
    localparam logic [1:0] REG_CNT  = 2'd2;
    localparam logic [1:0] REG_ACT  = 2'd3;

    localparam int CTRL_DONE_BIT   = 15;
    localparam int CTRL_IE_BIT     = 13;
    localparam int CTRL_ERR_BIT    = 10;
    localparam int CTRL_ERRCLR_BIT = 8;

    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_WAIT = 1'b1
    } fetch_state_e;
endpackage

// File: rtl/dts_rr_pick.sv
// Round-robin chooser: finds the first requesting line strictly after `last`.
// Assumes N is a power of two, so that SEL_W bits index every line.
module dts_rr_pick #(
    parameter int N = 16,
    localparam int SEL_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    input  logic [SEL_W-1:0] last,
    output logic             any,
    output logic [SEL_W-1:0] pick
);
    // Scan the lines in rotated order, beginning one past the last winner.
    always_comb begin
        int idx;
        any  = 1'b0;
        pick = '0;
        for (int i = 1; i <= N; i++) begin
            idx = (int'(last) + i) % N;
            if (!any && req[idx]) begin
                any  = 1'b1;
                pick = SEL_W'(idx);
            end
        end
    end
endmodule

// File: rtl/dts_line_ctx.sv
// Per-line address and count storage.
// It has one software port, addressed by the line select, and one hardware
// step port that advances the line being fetched. Software writes take
// priority over the step.
module dts_line_ctx #(
    parameter int N  = 16,
    parameter int DW = 16,
    localparam int SEL_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sw_sel,
    input  logic             sw_addr_we,
    input  logic             sw_cnt_we,
    input  logic [DW-1:0]    sw_wdata,
    output logic [DW-1:0]    sw_addr_rd,
    output logic [DW-1:0]    sw_cnt_rd,
    input  logic             step_en,
    input  logic [SEL_W-1:0] step_line,
    output logic [DW-1:0]    cur_addr,
    output logic             cur_last
);
    logic [DW-1:0] addr_q [N];
    logic [DW-1:0] cnt_q  [N];

    // Load from software, or advance the address and count of the fetched line.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                addr_q[i] <= '0;
                cnt_q[i]  <= '0;
            end else begin
                if (sw_addr_we && sw_sel == SEL_W'(i))
                    addr_q[i] <= sw_wdata;
                else if (step_en && step_line == SEL_W'(i))
                    addr_q[i] <= addr_q[i] + 1'b1;
                if (sw_cnt_we && sw_sel == SEL_W'(i))
                    cnt_q[i] <= sw_wdata;
                else if (step_en && step_line == SEL_W'(i))
                    cnt_q[i] <= cnt_q[i] + 1'b1;
            end
        end
    end

    // Views for software readback and for the fetch in progress.
    always_comb begin
        sw_addr_rd = addr_q[sw_sel];
        sw_cnt_rd  = cnt_q[sw_sel];
        cur_addr   = addr_q[step_line];
        cur_last   = (cnt_q[step_line] == '1);
    end
endmodule

// File: rtl/dts_fetch_seq.sv
// Fetch sequencer. It picks an eligible line, holds a memory request until
// the grant, then delivers the byte or reports an error.
// Assumes mem_gnt is only ever seen while mem_req is high.
module dts_fetch_seq #(
    parameter int N  = 16,
    parameter int BW = 8,
    localparam int SEL_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     eligible,
    input  logic [N-1:0]     line_active,
    input  logic             mem_gnt,
    input  logic             mem_err,
    input  logic [BW-1:0]    mem_rdata,
    input  logic             cur_last,
    output logic             mem_req,
    output logic [SEL_W-1:0] cur_line,
    output logic             step_en,
    output logic             done_pulse,
    output logic             err_pulse,
    output logic [N-1:0]     tx_valid,
    output logic [BW-1:0]    tx_data
);
    import dts_pkg::*;

    fetch_state_e     state_q;
    logic [SEL_W-1:0] line_q;
    logic [SEL_W-1:0] last_q;
    logic             pick_any;
    logic [SEL_W-1:0] pick_line;
    logic             accept;
    logic [N-1:0]     tx_valid_q;
    logic [BW-1:0]    tx_data_q;

    dts_rr_pick #(.N(N)) pick_i (
        .req  (eligible),
        .last (last_q),
        .any  (pick_any),
        .pick (pick_line)
    );

    // Sequencer state: choose a line when idle, wait for the grant otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            line_q  <= '0;
            last_q  <= SEL_W'(N - 1);
        end else if (state_q == FS_IDLE) begin
            if (pick_any) begin
                line_q  <= pick_line;
                last_q  <= pick_line;
                state_q <= FS_WAIT;
            end
        end else if (mem_gnt) begin
            state_q <= FS_IDLE;
        end
    end

    // Decode the grant cycle into step, finish and error events.
    always_comb begin
        accept     = (state_q == FS_WAIT) && mem_gnt;
        step_en    = accept && line_active[line_q] && !mem_err;
        done_pulse = step_en && cur_last;
        err_pulse  = accept && mem_err;
        mem_req    = (state_q == FS_WAIT);
        cur_line   = line_q;
    end

    // Register the delivered byte toward the selected transmitter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid_q <= '0;
            tx_data_q  <= '0;
        end else begin
            tx_valid_q <= step_en ? (N'(1) << line_q) : '0;
            if (step_en)
                tx_data_q <= mem_rdata;
        end
    end

    assign tx_valid = tx_valid_q;
    assign tx_data  = tx_data_q;
endmodule

// File: rtl/dma_tx_scheduler.sv
// DMA transmit scheduler top. It holds the control word, the active mask and
// the flags, and joins the line storage to the fetch sequencer.
// Assumes N is at most the register width and a power of two.
module dma_tx_scheduler #(
    parameter int N  = 16,
    parameter int DW = 16,
    parameter int BW = 8,
    localparam int SEL_W = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_idx,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          mem_req,
    output logic [DW-1:0] mem_addr,
    input  logic          mem_gnt,
    input  logic [BW-1:0] mem_rdata,
    input  logic          mem_err,
    input  logic [N-1:0]  tx_ready,
    output logic [N-1:0]  tx_valid,
    output logic [BW-1:0] tx_data,
    output logic          irq
);
    import dts_pkg::*;

    logic [SEL_W-1:0] sel_q;
    logic             ie_q;
    logic             done_flag_q;
    logic             err_flag_q;
    logic [N-1:0]     active_q;
    logic [N-1:0]     end_mask;
    logic [DW-1:0]    ctrl_rd;
    logic [DW-1:0]    addr_rd;
    logic [DW-1:0]    cnt_rd;
    logic [SEL_W-1:0] cur_line;
    logic             cur_last;
    logic             step_en;
    logic             done_pulse;
    logic             err_pulse;
    logic             ctrl_we;
    logic             act_we;

    assign ctrl_we = reg_we && (reg_idx == REG_CTRL);
    assign act_we  = reg_we && (reg_idx == REG_ACT);

    dts_line_ctx #(.N(N), .DW(DW)) ctx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_sel     (sel_q),
        .sw_addr_we (reg_we && (reg_idx == REG_ADDR)),
        .sw_cnt_we  (reg_we && (reg_idx == REG_CNT)),
        .sw_wdata   (reg_wdata),
        .sw_addr_rd (addr_rd),
        .sw_cnt_rd  (cnt_rd),
        .step_en    (step_en),
        .step_line  (cur_line),
        .cur_addr   (mem_addr),
        .cur_last   (cur_last)
    );

    dts_fetch_seq #(.N(N), .BW(BW)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .eligible    (active_q & tx_ready),
        .line_active (active_q),
        .mem_gnt     (mem_gnt),
        .mem_err     (mem_err),
        .mem_rdata   (mem_rdata),
        .cur_last    (cur_last),
        .mem_req     (mem_req),
        .cur_line    (cur_line),
        .step_en     (step_en),
        .done_pulse  (done_pulse),
        .err_pulse   (err_pulse),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data)
    );

    // Control fields: line select, enable, and the two sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q       <= '0;
            ie_q        <= 1'b0;
            done_flag_q <= 1'b0;
            err_flag_q  <= 1'b0;
        end else begin
            if (ctrl_we) begin
                sel_q <= reg_wdata[SEL_W-1:0];
                ie_q  <= reg_wdata[CTRL_IE_BIT];
            end
            if (done_pulse)
                done_flag_q <= 1'b1;
            else if (ctrl_we && !reg_wdata[CTRL_DONE_BIT])
                done_flag_q <= 1'b0;
            if (err_pulse)
                err_flag_q <= 1'b1;
            else if (ctrl_we && reg_wdata[CTRL_ERRCLR_BIT])
                err_flag_q <= 1'b0;
        end
    end

    assign end_mask = (done_pulse || err_pulse) ? (N'(1) << cur_line) : '0;

    // Active mask: a software write wins, otherwise finished lines drop out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= '0;
        else if (act_we)
            active_q <= reg_wdata[N-1:0];
        else
            active_q <= active_q & ~end_mask;
    end

    // Register readback multiplexer and interrupt output.
    always_comb begin
        ctrl_rd                = '0;
        ctrl_rd[SEL_W-1:0]     = sel_q;
        ctrl_rd[CTRL_DONE_BIT] = done_flag_q;
        ctrl_rd[CTRL_IE_BIT]   = ie_q;
        ctrl_rd[CTRL_ERR_BIT]  = err_flag_q;
        case (reg_idx)
            REG_CTRL: reg_rdata = ctrl_rd;
            REG_ADDR: reg_rdata = addr_rd;
            REG_CNT:  reg_rdata = cnt_rd;
            default:  reg_rdata = DW'(active_q);
        endcase
        irq = ie_q && (done_flag_q || err_flag_q);
    end
endmodule

// File: rtl/dts_checker.sv
// Protocol checker for the DMA transmit scheduler, bound to the top module.
// Assumes tx_ready is held high until a byte is delivered.
module dts_checker #(
    parameter int N  = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_gnt,
    input logic          mem_err,
    input logic [DW-1:0] mem_addr,
    input logic [N-1:0]  tx_ready,
    input logic [N-1:0]  tx_valid,
    input logic          err_flag
);
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    assert_valid_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_valid));

    assert_valid_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_valid & ~$past(tx_ready)) == '0));

    assert_valid_after_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_valid) |-> $past(mem_req && mem_gnt && !mem_err));

    assert_err_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && mem_err) |=> err_flag);

    assert_no_valid_on_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && mem_err) |=> (tx_valid == '0));
endmodule

bind dma_tx_scheduler dts_checker #(.N(N), .DW(DW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_gnt  (mem_gnt),
    .mem_err  (mem_err),
    .mem_addr (mem_addr),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .err_flag (err_flag_q)
);

// File: tb/dma_tx_scheduler_tb.sv
// Self-checking bench: sweeps every line with its own length, then covers the
// error, flag re-arm, readiness and cancel cases.
module dma_tx_scheduler_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_idx = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_gnt = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic [N-1:0] tx_ready = '1;
    logic [N-1:0] tx_valid;
    logic [7:0]  tx_data;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc = 0;
    int req_cycles = 0;
    int bytes_total = 0;
    logic [15:0] start_a [N];
    int          got     [N];
    int          len_e   [N];
    logic [N-1:0] model_act = '0;
    int          last_l = N - 1;
    bit          order_on = 1'b0;

    dma_tx_scheduler dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .tx_ready(tx_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Memory model (grant withheld one cycle in three) and delivery monitor.
    always @(negedge clk) begin
        cyc++;
        if (mem_req) req_cycles++;
        if (mem_req && !mem_gnt && (cyc % 3 != 2)) begin
            mem_gnt   <= 1'b1;
            mem_rdata <= mem_byte(mem_addr);
            mem_err   <= (mem_addr >= 16'hF000) && (mem_addr < 16'hF010);
        end else begin
            mem_gnt <= 1'b0;
            mem_err <= 1'b0;
        end
        if (rst_n && tx_valid != '0) begin
            chk("R6 onehot strobe", 32'($countones(tx_valid)), 32'd1);
            for (int l = 0; l < N; l++) begin
                if (tx_valid[l]) begin
                    bytes_total++;
                    chk("R3 byte data", {24'd0, tx_data},
                        {24'd0, mem_byte(start_a[l] + 16'(got[l]))});
                    if (order_on) begin
                        int exp_l;
                        exp_l = -1;
                        for (int k = 1; k <= N; k++)
                            if (exp_l < 0 && model_act[(last_l + k) % N])
                                exp_l = (last_l + k) % N;
                        chk("R5 round-robin line", 32'(l), 32'(exp_l));
                        last_l = l;
                    end
                    got[l]++;
                    if (got[l] >= len_e[l]) model_act[l] = 1'b0;
                end
            end
        end
    end

    task automatic wr(input logic [1:0] idx, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, output logic [15:0] d);
        @(negedge clk);
        reg_idx = idx;
        #1 d = reg_rdata;
    endtask

    task automatic prog(input int l, input logic [15:0] a, input int n);
        wr(2'd0, 16'hA000 | 16'(l));
        wr(2'd1, a);
        wr(2'd2, 16'(-n));
        start_a[l] = a; got[l] = 0; len_e[l] = n;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int t = 0; t < 5000; t++) begin
            rd(2'd3, v);
            if (v == '0) break;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int req0, got0;
        for (int l = 0; l < N; l++) begin start_a[l] = '0; got[l] = 0; len_e[l] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(2'd0, v); chk("R1 ctrl reset", 32'(v), 32'd0);
        rd(2'd3, v); chk("R1 active reset", 32'(v), 32'd0);
        rd(2'd1, v); chk("R1 addr reset", 32'(v), 32'd0);
        rd(2'd2, v); chk("R1 count reset", 32'(v), 32'd0);
        chk("R1 outputs reset", {29'd0, mem_req, |tx_valid, irq}, 32'd0);

        // R2..R5, R8, R10: every line, length line+1, all ready
        for (int l = 0; l < N; l++) prog(l, 16'h1000 + 16'(l * 256), l + 1);
        rd(2'd0, v); chk("R2 ctrl select/enable", 32'(v), 32'h0000200F);
        model_act = '1; last_l = N - 1; order_on = 1'b1;
        wr(2'd3, 16'hFFFF);
        wait_idle();
        order_on = 1'b0;
        for (int l = 0; l < N; l++) begin
            chk("R3 byte total per line", 32'(got[l]), 32'(l + 1));
            wr(2'd0, 16'hA000 | 16'(l));
            rd(2'd1, v); chk("R3 address advanced", 32'(v), 32'(16'h1000 + 16'(l * 256) + 16'(l + 1)));
            rd(2'd2, v); chk("R3 count reached zero", 32'(v), 32'd0);
        end
        rd(2'd3, v); chk("R4 mask cleared on finish", 32'(v), 32'd0);
        rd(2'd0, v); chk("R8 done flag set", 32'(v[15]), 32'd1);
        chk("R10 irq with done", 32'(irq), 32'd1);

        // R8: writing zero clears
        wr(2'd0, 16'h2000);
        rd(2'd0, v); chk("R8 done flag cleared", 32'(v[15]), 32'd0);
        chk("R10 irq low after clear", 32'(irq), 32'd0);

        // R9: error at address F000 after two good bytes
        prog(5, 16'hEFFE, 5);
        wr(2'd3, 16'h0020);
        wait_idle();
        chk("R9 bytes before error", 32'(got[5]), 32'd2);
        rd(2'd0, v); chk("R9 error flag", 32'(v[10]), 32'd1);
        chk("R9 no done flag", 32'(v[15]), 32'd0);
        chk("R10 irq with error", 32'(irq), 32'd1);
        rd(2'd1, v); chk("R9 address held", 32'(v), 32'h0000F000);
        rd(2'd2, v); chk("R9 count held", 32'(v), 32'h0000FFFD);
        rd(2'd3, v); chk("R4 mask cleared on error", 32'(v), 32'd0);
        wr(2'd0, 16'hA105);
        rd(2'd0, v); chk("R9 error flag cleared", 32'(v[10]), 32'd0);
        chk("R10 irq low after error clear", 32'(irq), 32'd0);

        // R8 re-arm, R10 enable gating
        prog(7, 16'h3300, 3);
        wr(2'd3, 16'h0080);
        wait_idle();
        chk("R3 three bytes line 7", 32'(got[7]), 32'd3);
        rd(2'd0, v); chk("R8 flag re-armed", 32'(v[15]), 32'd1);
        wr(2'd0, 16'h8007);
        chk("R10 irq gated by enable", 32'(irq), 32'd0);
        rd(2'd0, v); chk("R10 flag kept while disabled", 32'(v[15]), 32'd1);
        wr(2'd0, 16'h2000);

        // R6: a line waits while its transmitter is not ready
        tx_ready[3] = 1'b0;
        prog(3, 16'h4400, 2);
        req0 = req_cycles;
        wr(2'd3, 16'h0008);
        repeat (20) @(negedge clk);
        chk("R6 no request while not ready", 32'(req_cycles - req0), 32'd0);
        chk("R6 no byte while not ready", 32'(got[3]), 32'd0);
        tx_ready[3] = 1'b1;
        wait_idle();
        chk("R6 bytes after ready", 32'(got[3]), 32'd2);

        // R11: cancel a waiting line
        tx_ready[9] = 1'b0;
        prog(9, 16'h5500, 4);
        wr(2'd3, 16'h0200);
        repeat (5) @(negedge clk);
        wr(2'd3, 16'h0000);
        tx_ready[9] = 1'b1;
        req0 = req_cycles; got0 = bytes_total;
        repeat (20) @(negedge clk);
        chk("R11 no request after cancel", 32'(req_cycles - req0), 32'd0);
        chk("R11 no byte after cancel", 32'(bytes_total - got0), 32'd0);
        rd(2'd1, v); chk("R11 address unchanged", 32'(v), 32'h00005500);
        rd(2'd3, v); chk("R11 mask stays clear", 32'(v), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule